// File: doc/BRIEF.md
# Six-Channel Shared-Period Windowed PWM

This block drives six PWM lines from one shared period counter. A frequency value sets the last count of the period: the counter climbs from 0 to that value and wraps, so the output rate is the selected tick rate divided by (value + 1). Each channel has its own start and end count, and its output is high for the counter values between them. A window may also wrap across the end of the period. Fixed rules decide the level when a start or end value falls outside the period.

The counter moves once per tick. The tick comes from one of two single-cycle enable inputs, a fast one or a low-power one, chosen by a control bit. A global enable starts all channels together. A software pause bit and an optional hardware pause input freeze the counter and the outputs. All settings are written through a simple synchronous write port. The block has no read-back.

Top module: `shared_period_pwm`

## Requirements
- R1: After reset every setting is 0, the counter is 0 and all six outputs are low.
- R2: A write with `wr_en` high stores `wr_data` at the clock edge. The address decodes as follows: 0 is the control word (bit 0 enable, bit 1 software pause, bit 2 hardware-pause enable, bit 3 tick select); 1 is the period value; 2 to 7 are the start counts of channels 0 to 5; 8 to 13 are their end counts. Only the low 14 bits of a count are kept. Other addresses change nothing.
- R3: The counter advances only on a cycle where the selected tick is high. Tick select 1 takes `fast_tick` and tick select 0 takes `lp_tick`. The unselected tick has no effect.
- R4: While running, the counter goes from 0 up to the period value and then returns to 0 on the next tick. If the counter is at or above the period value, the next tick returns it to 0.
- R5: When start < end and end ≤ period value, a channel output is high when the counter is in [start, end) and low otherwise. The output register follows the counter one clock later.
- R6: When start > end and start ≤ period value, the window wraps. The output is high when the counter ≥ start or the counter < end.
- R7: If start is greater than the period value, or end equals start, the channel output stays 0.
- R8: If end is greater than the period value and start is not, the channel output stays 1.
- R9: While enabled and software-paused, the counter and all outputs keep their values, even if settings are rewritten.
- R10: The `hw_pause` input pauses the block in the same way as the software pause, but only when the hardware-pause enable bit is 1. Otherwise it is ignored.
- R11: While disabled, the counter is held at 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the setting port |
| wr_addr | input | 4 | Setting address |
| wr_data | input | 16 | Setting data |
| fast_tick | input | 1 | Fast-domain tick enable, one clock wide |
| lp_tick | input | 1 | Low-power-domain tick enable, one clock wide |
| hw_pause | input | 1 | External pause request |
| pwm_o | output | 6 | Channel outputs, bit n is channel n |

## Verification
Two actions can fall in the same cycle: a counter wrap or step, and a pause or setting write. A pause raised on the cycle of a tick must win, and a period or window rewrite must act only from the next edge on. The random stimulus drives ticks, pause pulses and writes on independent random draws, so these collisions happen often, including period rewrites below the current count. Every cycle, all six outputs are compared against a model built from the requirements. That model applies the old settings at the edge and the write after it.

// File: rtl/spwm_pkg.sv
// Package: shared sizes and the control-word layout for the shared-period PWM.
// Assumes a 16-bit write port; counts narrower than that are truncated.
package spwm_pkg;

    localparam int DATA_W = 16;

    // Control word bit positions.
    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_SWP_BIT   = 1;
    localparam int CTL_HWPEN_BIT = 2;
    localparam int CTL_SEL_BIT   = 3;

    typedef struct packed {
        logic tick_sel;
        logic hw_pause_en;
        logic sw_pause;
        logic enable;
    } spwm_ctl_t;

endpackage

// File: rtl/spwm_regs.sv
// Module: setting store for the shared-period PWM.
// Holds the control word, period value and per-channel start/end counts.
// Assumes writes are single-cycle strobes synchronous to clk.
module spwm_regs
    import spwm_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 14,
    parameter int ADDR_W = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    output spwm_ctl_t                       ctl,
    output logic [CNT_W-1:0]                period,
    output logic [NUM_CH-1:0][CNT_W-1:0]    start_cnt,
    output logic [NUM_CH-1:0][CNT_W-1:0]    end_cnt
);

    localparam int ADDR_CTL   = 0;
    localparam int ADDR_PER   = 1;
    localparam int START_BASE = 2;
    localparam int END_BASE   = START_BASE + NUM_CH;

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(ADDR_CTL)) begin
            ctl.enable      <= wr_data[CTL_EN_BIT];
            ctl.sw_pause    <= wr_data[CTL_SWP_BIT];
            ctl.hw_pause_en <= wr_data[CTL_HWPEN_BIT];
            ctl.tick_sel    <= wr_data[CTL_SEL_BIT];
        end
    end

    // Period (last count) register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(ADDR_PER)) begin
            period <= wr_data[CNT_W-1:0];
        end
    end

    // Per-channel start and end registers.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch_regs
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_cnt[ch] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(START_BASE + ch)) begin
                start_cnt[ch] <= wr_data[CNT_W-1:0];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                end_cnt[ch] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(END_BASE + ch)) begin
                end_cnt[ch] <= wr_data[CNT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/spwm_period_ctr.sv
// Module: shared period counter.
// Counts 0..period on each tick while running and wraps to 0; frozen while
// paused; cleared while disabled. A count at or above period wraps on the next tick.
module spwm_period_ctr #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count
);

    logic at_last;

    // Detect the end of the period (also covers a count left above a shrunken period).
    always_comb at_last = (count >= period);

    // Advance, wrap, hold or clear the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!enable) begin
            count <= '0;
        end else if (run && tick) begin
            count <= at_last ? '0 : count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/spwm_channel.sv
// Module: one windowed PWM channel.
// Computes the window level from the shared count and registers it while
// running; holds while paused; forces low while disabled.
module spwm_channel #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             run,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] start_cnt,
    input  logic [CNT_W-1:0] end_cnt,
    output logic             pwm
);

    logic never_on;
    logic always_on;
    logic after_start;
    logic before_end;
    logic level;

    // Classify the window and compute the level for the current count.
    always_comb begin
        never_on    = (start_cnt > period) || (end_cnt == start_cnt);
        always_on   = (end_cnt > period);
        after_start = (count >= start_cnt);
        before_end  = (count < end_cnt);
        if (never_on) begin
            level = 1'b0;
        end else if (always_on) begin
            level = 1'b1;
        end else if (start_cnt < end_cnt) begin
            level = after_start && before_end;
        end else begin
            level = after_start || before_end;
        end
    end

    // Register the output level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm <= 1'b0;
        end else if (!enable) begin
            pwm <= 1'b0;
        end else if (run) begin
            pwm <= level;
        end
    end

endmodule

// File: rtl/shared_period_pwm.sv
// Module: six-channel PWM sharing one period counter (top).
// Selects the tick source, combines the pauses, and fans the shared count out
// to one windowed channel per output. Assumes hw_pause and ticks are synchronous.
module shared_period_pwm
    import spwm_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 14,
    parameter int ADDR_W = $clog2(2 + 2 * NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fast_tick,
    input  logic              lp_tick,
    input  logic              hw_pause,
    output logic [NUM_CH-1:0] pwm_o
);

    spwm_ctl_t                      ctl;
    logic [CNT_W-1:0]               period;
    logic [NUM_CH-1:0][CNT_W-1:0]   start_cnt;
    logic [NUM_CH-1:0][CNT_W-1:0]   end_cnt;
    logic [CNT_W-1:0]               count;
    logic                           tick_w;
    logic                           pause_w;
    logic                           run_w;

    // Tick source selection and pause combination.
    always_comb begin
        tick_w  = ctl.tick_sel ? fast_tick : lp_tick;
        pause_w = ctl.sw_pause || (ctl.hw_pause_en && hw_pause);
        run_w   = ctl.enable && !pause_w;
    end

    spwm_regs #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ctl       (ctl),
        .period    (period),
        .start_cnt (start_cnt),
        .end_cnt   (end_cnt)
    );

    spwm_period_ctr #(
        .CNT_W (CNT_W)
    ) i_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (ctl.enable),
        .run    (run_w),
        .tick   (tick_w),
        .period (period),
        .count  (count)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        spwm_channel #(
            .CNT_W (CNT_W)
        ) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (ctl.enable),
            .run       (run_w),
            .count     (count),
            .period    (period),
            .start_cnt (start_cnt[ch]),
            .end_cnt   (end_cnt[ch]),
            .pwm       (pwm_o[ch])
        );
    end

endmodule

// File: rtl/spwm_checker.sv
// Module: temporal checks for shared_period_pwm, attached by bind.
module spwm_checker #(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              sw_pause,
    input logic              hw_pause_en,
    input logic              hw_pause,
    input logic              tick_sel,
    input logic              fast_tick,
    input logic              lp_tick,
    input logic [CNT_W-1:0]  period,
    input logic [CNT_W-1:0]  count,
    input logic [NUM_CH-1:0] pwm_o
);

    logic paused;
    logic sel_tick;
    always_comb begin
        paused   = sw_pause || (hw_pause_en && hw_pause);
        sel_tick = tick_sel ? fast_tick : lp_tick;
    end

    assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (count == '0) && (pwm_o == '0));

    assert_pause_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sw_pause) |=> $stable(count) && $stable(pwm_o));

    assert_hw_pause_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && hw_pause_en && hw_pause) |=> $stable(count) && $stable(pwm_o));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !paused && sel_tick && count >= period) |=> (count == '0));

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !paused && sel_tick && count < period) |=> (count == $past(count) + CNT_W'(1)));

    assert_lp_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick_sel && !lp_tick) |=> $stable(count));

    assert_fast_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick_sel && !fast_tick) |=> $stable(count));

endmodule

bind shared_period_pwm spwm_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) i_spwm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (ctl.enable),
    .sw_pause    (ctl.sw_pause),
    .hw_pause_en (ctl.hw_pause_en),
    .hw_pause    (hw_pause),
    .tick_sel    (ctl.tick_sel),
    .fast_tick   (fast_tick),
    .lp_tick     (lp_tick),
    .period      (period),
    .count       (count),
    .pwm_o       (pwm_o)
);

// File: tb/test_shared_period_pwm.sv
// Bench: directed corners plus seeded random stimulus, compared every cycle
// against a requirement-level model of counter and windows.
module test_shared_period_pwm;

    localparam int NCH = 6;
    localparam int CW  = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        fast_tick = 1'b0;
    logic        lp_tick = 1'b0;
    logic        hw_pause = 1'b0;
    logic [5:0]  pwm_o;

    int tests_run = 0;
    int tests_failed = 0;
    string phase = "";

    // Model state.
    logic          m_en, m_sw, m_hwen, m_sel;
    logic [CW-1:0] m_per, m_cnt;
    logic [CW-1:0] m_s [NCH];
    logic [CW-1:0] m_e [NCH];
    logic [NCH-1:0] m_out;
    string          m_tag [NCH];

    always #5 clk = ~clk;

    shared_period_pwm i_shared_period_pwm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fast_tick(fast_tick), .lp_tick(lp_tick),
        .hw_pause(hw_pause), .pwm_o(pwm_o)
    );

    function automatic logic win(input logic [CW-1:0] c, s, e, p);
        if (s > p || e == s) return 1'b0;         // R7
        if (e > p) return 1'b1;                   // R8
        if (s < e) return (c >= s) && (c < e);    // R5
        return (c >= s) || (c < e);               // R6
    endfunction

    function automatic string cls(input logic [CW-1:0] s, e, p);
        if (s > p || e == s) return "R7";
        if (e > p) return "R8";
        if (s < e) return "R5";
        return "R6";
    endfunction

    task automatic model_reset();
        m_en = 0; m_sw = 0; m_hwen = 0; m_sel = 0; m_per = '0; m_cnt = '0; m_out = '0;
        for (int i = 0; i < NCH; i++) begin m_s[i] = '0; m_e[i] = '0; end
    endtask

    task automatic check(input string req, input logic act, input logic exp, input int ch);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s [%s] ch%0d actual=%b expected=%b t=%0t", req, phase, ch, act, exp, $time);
        end
    endtask

    // One clock: drive at this point, update model after the edge, compare 1 ns later.
    task automatic cyc(input logic we, input logic [3:0] a, input logic [15:0] d,
                       input logic ft, input logic lt, input logic hp);
        logic tk, pz, rn;
        logic [NCH-1:0] nout;
        wr_en = we; wr_addr = a; wr_data = d; fast_tick = ft; lp_tick = lt; hw_pause = hp;
        @(posedge clk);
        tk = m_sel ? ft : lt;
        pz = m_sw | (m_hwen & hp);
        rn = m_en & ~pz;
        for (int i = 0; i < NCH; i++) begin
            if (!m_en)       begin nout[i] = 1'b0; m_tag[i] = "R11"; end
            else if (!rn)    begin nout[i] = m_out[i]; m_tag[i] = m_sw ? "R9" : "R10"; end
            else             begin nout[i] = win(m_cnt, m_s[i], m_e[i], m_per); m_tag[i] = cls(m_s[i], m_e[i], m_per); end
        end
        m_out = nout;
        if (!m_en) m_cnt = '0;
        else if (rn && tk) m_cnt = (m_cnt >= m_per) ? '0 : m_cnt + 1'b1;
        if (we) begin
            if (a == 0) begin m_en = d[0]; m_sw = d[1]; m_hwen = d[2]; m_sel = d[3]; end
            else if (a == 1) m_per = d[CW-1:0];
            else if (a >= 2 && a < 8) m_s[a-2] = d[CW-1:0];
            else if (a >= 8 && a < 14) m_e[a-8] = d[CW-1:0];
        end
        #1;
        for (int i = 0; i < NCH; i++) check(m_tag[i], pwm_o[i], m_out[i], i);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        cyc(1'b1, a, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic run(input int n, input logic ft, input logic lt, input logic hp);
        for (int k = 0; k < n; k++) cyc(1'b0, 4'd0, 16'd0, ft, lt, hp);
    endtask

    initial begin
        #(200000 * 10);
        tests_failed++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        phase = "R1";
        for (int i = 0; i < NCH; i++) check("R1", pwm_o[i], 1'b0, i);

        // R2: program a mixed set of windows through the address map.
        phase = "R2";
        wr(4'd1, 16'hC009);                 // period 9 (upper bits dropped)
        wr(4'd2, 16'd2);  wr(4'd8,  16'd5);  // ch0 R5
        wr(4'd3, 16'd7);  wr(4'd9,  16'd3);  // ch1 R6
        wr(4'd4, 16'd12); wr(4'd10, 16'd4);  // ch2 R7 start beyond period
        wr(4'd5, 16'd4);  wr(4'd11, 16'd4);  // ch3 R7 equal
        wr(4'd6, 16'd3);  wr(4'd12, 16'd15); // ch4 R8
        wr(4'd7, 16'd0);  wr(4'd13, 16'd10); // ch5 R8
        wr(4'd15, 16'hFFFF);                 // unmapped, no effect
        run(3, 1'b1, 1'b1, 1'b0);            // still disabled: R11

        phase = "R4 R5 R6 fast";
        wr(4'd0, 16'h0009);                  // enable, fast tick
        run(40, 1'b1, 1'b0, 1'b0);
        phase = "R3 lp ignored/fast taken";
        run(10, 1'b0, 1'b1, 1'b0);
        wr(4'd0, 16'h0001);                  // low-power tick
        phase = "R3 fast ignored";
        run(10, 1'b1, 1'b0, 1'b0);
        phase = "R3 lp";
        run(30, 1'b0, 1'b1, 1'b0);

        phase = "R9 sw pause";
        wr(4'd0, 16'h0003);
        wr(4'd8, 16'd9);                     // rewrite during pause
        run(10, 1'b1, 1'b1, 1'b0);
        phase = "R10 hw pause ignored";
        wr(4'd0, 16'h0009);
        run(12, 1'b1, 1'b1, 1'b1);
        phase = "R10 hw pause honoured";
        wr(4'd0, 16'h000D);
        run(12, 1'b1, 1'b1, 1'b1);
        run(12, 1'b1, 1'b1, 1'b0);
        phase = "R11 disable";
        wr(4'd0, 16'h0000);
        run(5, 1'b1, 1'b1, 1'b0);
        phase = "R4 period zero";
        wr(4'd1, 16'd0); wr(4'd0, 16'h0009);
        run(8, 1'b1, 1'b1, 1'b0);

        phase = "random";
        for (int k = 0; k < 6000; k++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 6) begin
                logic [3:0] a;
                logic [15:0] d;
                a = 4'($urandom_range(0, 14));
                if (a == 0) d = {12'd0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                                 ($urandom_range(0, 5) == 0) ? 1'b1 : 1'b0, ($urandom_range(0, 9) != 0) ? 1'b1 : 1'b0};
                else d = 16'($urandom_range(0, 24));
                cyc(1'b1, a, d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    ($urandom_range(0, 7) == 0) ? 1'b1 : 1'b0);
            end else begin
                cyc(1'b0, 4'd0, 16'd0, ($urandom_range(0, 3) != 0) ? 1'b1 : 1'b0,
                    1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0) ? 1'b1 : 1'b0);
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule